// File: doc/BRIEF.md
# PLL Frequency Update Handshake Controller

This block commits a freshly programmed integer multiplier and fraction to a PLL that is already running. It does this without going through a full power-up sequence. A single `start` pulse launches the commit. The controller raises an update request and gives the PLL time to capture the request. It then runs one of two acknowledge handshakes, waits for the output to settle, and reports either `done` or `timeout`. All waits are counted in `tick` pulses, where one tick is one microsecond.

There are two handshake variants, chosen by the `bypass` input. With `bypass` high, the controller clears the request itself once it sees the acknowledge. With `bypass` low, the PLL side clears the request as soon as acknowledge rises, and the controller polls until the request reads back low. In both variants the controller then polls for acknowledge to drop and runs a settle delay. The block also contains a small behavioural stand-in for the PLL's acknowledge logic. It raises `ack` a programmable number of clocks after the request and holds it for a fixed time, so both variants can be exercised in one place.

Top module: `pll_update_seq`

## Requirements
- R1: A `start` pulse with `pll_on` low or `dyn_ok` low completes at once. `done` is high on the clock edge that samples `start`, `upd_req` never rises, and `timeout` is low.
- R2: After the request is raised, the controller lets LATCH_US+1 ticks (default 2) pass before it evaluates its first poll. In bypass mode the request therefore drops at the third tick after `start` when acknowledge is already high.
- R3: In bypass mode (`bypass`=1 at `start`), the request is cleared only by the controller, on a tick at which `ack` is seen high. It never drops on a clock without a tick.
- R4: In non-bypass mode, `upd_req` goes low one clock after `ack` is first high, whatever the tick phase. The controller moves on when it samples the request low on a tick.
- R5: In both modes the controller next polls for `ack` low, then counts SETTLE_US+1 further ticks (default 11) before raising `done`. With a tick on every clock and `ack_dly`=D, `done` rises 17+D clocks after the `start` edge.
- R6: Each poll allows at most POLL_MAX (default 100) tick samples. If the last sample fails, `timeout` rises. With a tick on every clock this happens 102 clocks after `start`. The boundary is `ack_dly`=99 in non-bypass mode and 100 in bypass mode: these succeed, and one more times out.
- R7: On timeout `upd_req` is low. `timeout` and `done` are held as levels, are never high together, and both clear on the next accepted `start`.
- R8: The PLL model raises `ack` ack_dly+1 clocks after `upd_req` rises (`ack_dly` ≥ 1) and holds it for ACK_HOLD clocks (default 4). It does not fire again until the request has returned low.
- R9: After reset, `upd_req`, `ack`, `busy`, `done` and `timeout` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request to commit new frequency values |
| pll_on | input | 1 | PLL is running and locked |
| dyn_ok | input | 1 | PLL supports on-the-fly reprogramming |
| bypass | input | 1 | 1: controller clears the request; 0: PLL side clears it |
| tick | input | 1 | One-clock pulse per microsecond |
| ack_dly | input | DW | PLL model: clocks from request to acknowledge, minus one |
| upd_req | output | 1 | Update request to the PLL |
| ack | output | 1 | Acknowledge from the PLL model |
| busy | output | 1 | Handshake in progress |
| done | output | 1 | Last commit completed (held until next start) |
| timeout | output | 1 | Last commit timed out (held until next start) |

## Verification
The bench drives the exact poll boundaries in both modes: non-bypass with delays 99 and 100, and bypass with 100 and 101. A design that counts 99 or 101 samples, or that tests the limit before the condition, flips one of these outcomes. Exact `done` latency exposes a settle or capture wait that is one tick short or long. Sparse ticks separate the two request-clear paths. If the controller cleared the request in bypass mode without a tick, or waited for a tick in non-bypass mode, the counted tick and clock totals would change. The skip path, and the holding and clearing of the flags across later starts, are checked at the outputs.

// File: rtl/pll_update_seq.sv
`timescale 1ns/1ps
module pll_update_seq #(
  parameter int POLL_MAX  = 100,
  parameter int SETTLE_US = 10,
  parameter int LATCH_US  = 1,
  parameter int ACK_HOLD  = 4,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pll_on,
  input  logic          dyn_ok,
  input  logic          bypass,
  input  logic          tick,
  input  logic [DW-1:0] ack_dly,
  output logic          upd_req,
  output logic          ack,
  output logic          busy,
  output logic          done,
  output logic          timeout
);
  localparam int CW = $clog2(POLL_MAX + SETTLE_US + LATCH_US + 2);

  typedef enum logic [2:0] {S_IDLE, S_LATCH, S_WSET, S_WREQ, S_WCLR, S_SETTLE} st_t;
  typedef enum logic [1:0] {M_IDLE, M_WAIT, M_HOLD, M_REL} mst_t;

  st_t          st;
  mst_t         mst;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mcnt;
  logic          req, done_r, to_r, bp_r, ack_r, hit, last;

  assign upd_req = req;
  assign ack     = ack_r;
  assign busy    = (st != S_IDLE);
  assign done    = done_r;
  assign timeout = to_r;
  assign last    = (cnt == CW'(POLL_MAX - 1));

  always_comb begin
    case (st)
      S_WSET:  hit = ack_r;
      S_WREQ:  hit = !req;
      S_WCLR:  hit = !ack_r;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; req <= 1'b0;
      done_r <= 1'b0; to_r <= 1'b0; bp_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            to_r <= 1'b0;
            if (pll_on && dyn_ok) begin
              done_r <= 1'b0;
              req    <= 1'b1;
              bp_r   <= bypass;
              cnt    <= '0;
              st     <= S_LATCH;
            end else begin
              done_r <= 1'b1;
            end
          end
        S_LATCH:
          if (tick) begin
            if (cnt == CW'(LATCH_US)) begin
              cnt <= '0;
              st  <= bp_r ? S_WSET : S_WREQ;
            end else cnt <= cnt + 1'b1;
          end
        S_WSET, S_WREQ, S_WCLR:
          if (tick) begin
            if (hit) begin
              cnt <= '0;
              st  <= (st == S_WCLR) ? S_SETTLE : S_WCLR;
              if (st == S_WSET) req <= 1'b0;
            end else if (last) begin
              req  <= 1'b0;
              to_r <= 1'b1;
              cnt  <= '0;
              st   <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
        S_SETTLE:
          if (tick) begin
            if (cnt == CW'(SETTLE_US)) begin
              done_r <= 1'b1;
              cnt    <= '0;
              st     <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
      if (!bp_r && ack_r && st != S_IDLE) req <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst <= M_IDLE; mcnt <= '0; ack_r <= 1'b0;
    end else begin
      case (mst)
        M_IDLE:
          if (req) begin
            mst  <= M_WAIT;
            mcnt <= DW'(1);
          end
        M_WAIT:
          if (!req) mst <= M_IDLE;
          else if (mcnt >= ack_dly) begin
            ack_r <= 1'b1;
            mcnt  <= DW'(1);
            mst   <= M_HOLD;
          end else mcnt <= mcnt + 1'b1;
        M_HOLD:
          if (mcnt == DW'(ACK_HOLD)) begin
            ack_r <= 1'b0;
            mst   <= M_REL;
          end else mcnt <= mcnt + 1'b1;
        default:
          if (!req) mst <= M_IDLE;
      endcase
    end
  end

  AST_SKIP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !(pll_on && dyn_ok)) |=> (done && !upd_req)); // R1
  AST_REQ_HELD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_req) |=> upd_req); // R2
  AST_BYPASS_CLEAR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bp_r && upd_req && !tick) |=> upd_req); // R3
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bp_r && ack && upd_req) |=> !upd_req); // R4
  AST_DONE_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(busy)) |-> !ack); // R5
  AST_TIMEOUT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !upd_req); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R7
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(upd_req)); // R8
endmodule

// File: tb/pll_update_seq_tb.sv
`timescale 1ns/1ps
module pll_update_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pll_on = 1'b0, dyn_ok = 1'b0;
  logic bypass = 1'b0, tick = 1'b1;
  logic [7:0] ack_dly = 8'd1;
  logic upd_req, ack, busy, done, timeout;
  int checks = 0, errors = 0, tdiv = 1, tph = 0;
  longint cyc = 0;

  pll_update_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_on(pll_on), .dyn_ok(dyn_ok),
    .bypass(bypass), .tick(tick), .ack_dly(ack_dly), .upd_req(upd_req), .ack(ack),
    .busy(busy), .done(done), .timeout(timeout));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tph  = (tph + 1 >= tdiv) ? 0 : tph + 1;
    tick = (tph == 0);
  end

  // fields: {pll_on, dyn_ok, bypass, expect_timeout, ack_dly[7:0], latency[11:0]}
  localparam logic [23:0] VEC [0:9] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 8'd1,   12'd18},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'd1,   12'd18},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'd5,   12'd22},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'd20,  12'd37},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'd99,  12'd116},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'd100, 12'd102},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'd100, 12'd117},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'd101, 12'd102},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd5,   12'd0},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'd5,   12'd0}
  };

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic on_i, input logic dyn_i, input logic bp_i,
                             input logic [7:0] d_i);
    @(negedge clk);
    pll_on = on_i; dyn_ok = dyn_i; bypass = bp_i; ack_dly = d_i; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_seq(input logic on_i, input logic dyn_i, input logic bp_i,
                         input logic [7:0] d_i, output int lat, output logic saw);
    pulse_start(on_i, dyn_i, bp_i, d_i);
    lat = 0;
    saw = upd_req;
    while (!done && !timeout && lat < 3000) begin
      @(posedge clk); #1;
      lat++;
      if (upd_req) saw = 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, hi, tk;
    logic saw;
    idle(3);
    #1;
    chk(!upd_req && !ack && !busy && !done && !timeout, "R9 reset state",
        {upd_req, ack, busy, done, timeout}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    for (int v = 0; v < 10; v++) begin
      logic [23:0] e;
      e = VEC[v];
      run_seq(e[23], e[22], e[21], e[19:12], lat, saw);
      chk(timeout == e[20] && done == !e[20], "R5/R6 outcome flag",
          {done, timeout}, {!e[20], e[20]});
      chk(lat == int'(e[11:0]), (e[23] && e[22]) ? "R5/R6 latency" : "R1 skip latency",
          lat, e[11:0]);
      chk(saw == (e[23] && e[22]), "R1 request raised only when allowed", saw, e[23] && e[22]);
      idle(12);
    end

    run_seq(1'b1, 1'b1, 1'b0, 8'd150, lat, saw);
    idle(20); #1;
    chk(timeout && !done && !upd_req, "R7 timeout held, request low",
        {timeout, done, upd_req}, 3'b100);
    pulse_start(1'b0, 1'b1, 1'b0, 8'd1);
    chk(!timeout && done, "R7 next start clears timeout", {timeout, done}, 2'b01);
    idle(5);

    run_seq(1'b1, 1'b1, 1'b1, 8'd3, lat, saw);
    idle(25); #1;
    chk(done && !timeout, "R7 done held", {done, timeout}, 2'b10);
    pulse_start(1'b1, 1'b1, 1'b0, 8'd3);
    chk(!done && busy, "R7 accepted start clears done", {done, busy}, 2'b01);
    while (busy) @(posedge clk);
    idle(12);

    tdiv = 3;
    pulse_start(1'b1, 1'b1, 1'b0, 8'd1);
    hi = 0;
    forever begin
      @(negedge clk); #1;
      if (!upd_req) break;
      hi++;
    end
    chk(hi == 3, "R4 auto-clear one clock after ack", hi, 3);
    lat = 0;
    while (!done && !timeout && lat < 3000) begin @(posedge clk); #1; lat++; end
    chk(done && !timeout, "R4 sparse tick completes", {done, timeout}, 2'b10);
    idle(12);

    tdiv = 2;
    pulse_start(1'b1, 1'b1, 1'b1, 8'd2);
    tk = 0;
    forever begin
      @(negedge clk); #1;
      if (!upd_req) break;
      if (tick) tk++;
    end
    chk(tk == 3, "R2/R3 bypass clear on third tick", tk, 3);
    lat = 0;
    while (!done && !timeout && lat < 3000) begin @(posedge clk); #1; lat++; end
    chk(done && !timeout, "R3 sparse tick completes", {done, timeout}, 2'b10);
    idle(12);

    tdiv = 1;
    pulse_start(1'b1, 1'b1, 1'b0, 8'd2);
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      if (ack) hi++;
    end
    chk(hi == 4, "R8 ack held for ACK_HOLD clocks", hi, 4);
    while (busy) @(posedge clk);
    idle(5); #1;
    chk(!ack && !upd_req, "R8 no second ack", {ack, upd_req}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule